// File: doc/BRIEF.md
# Active-Zero-State Three-Phase PWM Modulator

This block drives the three high-side gate commands of a three-phase inverter with centre-aligned pulses. All three phases share one symmetric up-down triangle carrier. Each phase has a compare level. In every sector except the zero vector, one phase runs with its set/clear actions swapped. The zero-vector interval is then filled by two opposing active vectors rather than a true zero state.

The surrounding control code writes a sector number, three compare levels and a half-period into shadow inputs. The block takes all of them together only at the bottom of the carrier. Duty and polarity therefore never change partway through a carrier period. Sector 0 and sector 7 both mean the zero vector: every compare level is forced beyond reach and every output stays high.

Top module: `azs_pwm_top`

## Requirements
- R1: The carrier counts 0, 1, …, P, P−1, …, 1 and repeats, so one carrier period lasts 2·P clock cycles, where P is the active half-period.
- R2: A normal-polarity phase goes high when the carrier is at zero, goes low at the up-count compare match and goes high again at the down-count match. With compare C and 0 < C < P it is high for 2·C cycles of each period. Each output is registered and changes on the clock edge that follows the cycle in which its event occurs.
- R3: An inverted phase goes low at carrier zero, goes high at the up-count match and goes low at the down-count match. With 0 < C < P it is high for 2·P − 2·C cycles of each period.
- R4: The inverted phase is chosen by sector: 1→B, 2→A, 3→C, 4→B, 5→A, 6→C. Phase bits are A=bit0, B=bit1, C=bit2. The other two phases use normal polarity.
- R5: Sectors 0 and 7 select normal polarity on all phases and force every compare level beyond the period, so all three outputs stay high.
- R6: The sector and the three compare levels are taken from their shadow inputs only in the cycle where the carrier is zero. A change in the middle of a period affects no output until the next zero.
- R7: A compare level of 0, or of P or more, gives no match. The phase then holds its zero-point level for the whole period: high when normal, low when inverted.
- R8: While the asynchronous active-low reset is asserted, all outputs are low and the carrier rests at zero, counting up.
- R9: The half-period P is loaded from its shadow input only at carrier zero. A new value sets the length of the following periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period_sh | input | CNT_W | Shadow half-period P |
| sector_sh | input | 3 | Shadow sector number (0..7) |
| cmp_a_sh | input | CNT_W | Shadow compare level, phase A |
| cmp_b_sh | input | CNT_W | Shadow compare level, phase B |
| cmp_c_sh | input | CNT_W | Shadow compare level, phase C |
| pwm_a | output | 1 | Phase A high-side command |
| pwm_b | output | 1 | Phase B high-side command |
| pwm_c | output | 1 | Phase C high-side command |

## Verification
Every sector value is applied with distinct compare levels on the three phases. The high time per period then shows which phase is inverted, and a swapped rotation or a wrong polarity changes one of the three counts. Compare levels of 0, exactly P and above P are set against mid-range levels on the other phases, and this separates a missing range guard from a wrong polarity. A cycle-exact waveform at a small period checks the edge timing of each event. In the same run, the shadows are rewritten in mid-period; the old waveform must finish unchanged, and this detects any latching outside carrier zero. A change of half-period shows whether the period value follows its shadow.

// File: rtl/azs_pwm_pkg.sv
package azs_pwm_pkg;

  localparam int SEC_W  = 3;
  localparam int NUM_PH = 3;

  typedef logic [NUM_PH-1:0] ph_mask_t;

  // Which phase runs with swapped actions in a given sector (A=bit0).
  function automatic ph_mask_t inv_mask_of(input logic [SEC_W-1:0] sec);
    case (sec)
      3'd1, 3'd4: inv_mask_of = 3'b010;
      3'd2, 3'd5: inv_mask_of = 3'b001;
      3'd3, 3'd6: inv_mask_of = 3'b100;
      default:    inv_mask_of = 3'b000;
    endcase
  endfunction

  function automatic logic is_zero_vec(input logic [SEC_W-1:0] sec);
    is_zero_vec = (sec == 3'd0) || (sec == 3'd7);
  endfunction

endpackage

// File: rtl/azs_carrier.sv
module azs_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_period_sh,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic             at_zero,
  output logic [CNT_W-1:0] prd_act
);

  logic [CNT_W-1:0] prd_eff;

  assign at_zero = (cnt == '0);
  assign prd_eff = at_zero ? half_period_sh : prd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_act <= '0;
    end else if (at_zero) begin
      prd_act <= half_period_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (dir_up) begin
      if (cnt >= prd_eff) begin
        if (prd_eff == '0) begin
          cnt <= '0;
        end else begin
          cnt    <= cnt - 1'b1;
          dir_up <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == {{(CNT_W-1){1'b0}}, 1'b1}) begin
        dir_up <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/azs_shadow.sv
module azs_shadow #(
  parameter int CNT_W = 16
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       load,
  input  logic [azs_pwm_pkg::SEC_W-1:0]              sector_sh,
  input  logic [azs_pwm_pkg::NUM_PH-1:0][CNT_W-1:0]  cmp_sh,
  output logic [azs_pwm_pkg::SEC_W-1:0]              sector_act,
  output logic [azs_pwm_pkg::NUM_PH-1:0][CNT_W-1:0]  cmp_act
);
  import azs_pwm_pkg::*;

  localparam logic [CNT_W-1:0] CMP_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_act <= '0;
      cmp_act    <= '{default: CMP_MAX};
    end else if (load) begin
      sector_act <= sector_sh;
      for (int i = 0; i < NUM_PH; i++) begin
        cmp_act[i] <= is_zero_vec(sector_sh) ? CMP_MAX : cmp_sh[i];
      end
    end
  end

endmodule

// File: rtl/azs_phase_out.sv
module azs_phase_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic             at_zero,
  input  logic [CNT_W-1:0] prd_act,
  input  logic [CNT_W-1:0] cmp,
  input  logic             inv_load,
  input  logic             inv_act,
  output logic             up_hit,
  output logic             dn_hit,
  output logic             pwm
);

  logic cmp_ok;
  logic hit;

  assign cmp_ok = (cmp != '0) && (cmp < prd_act);
  assign hit    = !at_zero && cmp_ok && (cnt == cmp);
  assign up_hit = hit && dir_up;
  assign dn_hit = hit && !dir_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm <= 1'b0;
    end else if (at_zero) begin
      pwm <= !inv_load;
    end else if (up_hit) begin
      pwm <= inv_act;
    end else if (dn_hit) begin
      pwm <= !inv_act;
    end
  end

endmodule

// File: rtl/azs_pwm_top.sv
module azs_pwm_top #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_period_sh,
  input  logic [2:0]       sector_sh,
  input  logic [CNT_W-1:0] cmp_a_sh,
  input  logic [CNT_W-1:0] cmp_b_sh,
  input  logic [CNT_W-1:0] cmp_c_sh,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             pwm_c
);
  import azs_pwm_pkg::*;

  logic [CNT_W-1:0]             cnt;
  logic                         dir_up;
  logic                         at_zero;
  logic [CNT_W-1:0]             prd_act;
  logic [SEC_W-1:0]             sector_act;
  logic [NUM_PH-1:0][CNT_W-1:0] cmp_sh;
  logic [NUM_PH-1:0][CNT_W-1:0] cmp_act;
  ph_mask_t                     inv_load;
  ph_mask_t                     inv_act;
  ph_mask_t                     up_hit;
  ph_mask_t                     dn_hit;
  ph_mask_t                     pwm;

  assign cmp_sh   = {cmp_c_sh, cmp_b_sh, cmp_a_sh};
  assign inv_load = inv_mask_of(sector_sh);
  assign inv_act  = inv_mask_of(sector_act);

  azs_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk            (clk),
    .rst_n          (rst_n),
    .half_period_sh (half_period_sh),
    .cnt            (cnt),
    .dir_up         (dir_up),
    .at_zero        (at_zero),
    .prd_act        (prd_act)
  );

  azs_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (at_zero),
    .sector_sh  (sector_sh),
    .cmp_sh     (cmp_sh),
    .sector_act (sector_act),
    .cmp_act    (cmp_act)
  );

  for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
    azs_phase_out #(.CNT_W(CNT_W)) u_ph (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .dir_up   (dir_up),
      .at_zero  (at_zero),
      .prd_act  (prd_act),
      .cmp      (cmp_act[g]),
      .inv_load (inv_load[g]),
      .inv_act  (inv_act[g]),
      .up_hit   (up_hit[g]),
      .dn_hit   (dn_hit[g]),
      .pwm      (pwm[g])
    );
  end

  assign pwm_a = pwm[0];
  assign pwm_b = pwm[1];
  assign pwm_c = pwm[2];

endmodule

// File: rtl/azs_pwm_chk.sv
module azs_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             dir_up,
  input logic             at_zero,
  input logic [CNT_W-1:0] prd_act,
  input logic [2:0]       sector_sh,
  input logic [2:0]       sector_act,
  input logic [2:0]       inv_act,
  input logic [2:0]       up_hit,
  input logic [2:0]       dn_hit,
  input logic [2:0]       pwm
);

  // R1
  carrier_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |-> (cnt <= prd_act));

  // R1
  carrier_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_up && !at_zero && (cnt < prd_act)) |=> (cnt == $past(cnt) + 1'b1));

  // R6
  sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> $stable(sector_act));

  // R4
  single_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inv_act));

  // R2
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |=> (pwm == ~inv_act));

  // R3
  up_match_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_hit != 3'b000) |=> ((pwm & $past(up_hit)) == (inv_act & $past(up_hit))));

  // R3
  dn_match_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_hit != 3'b000) |=> ((pwm & $past(dn_hit)) == (~inv_act & $past(dn_hit))));

  // R5
  zero_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && ((sector_sh == 3'd0) || (sector_sh == 3'd7))) |=> (pwm == 3'b111));

  // R7
  no_hit_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_hit | dn_hit) != 3'b000) |-> ((cnt != '0) && (cnt < prd_act)));

endmodule

bind azs_pwm_top azs_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt        (cnt),
  .dir_up     (dir_up),
  .at_zero    (at_zero),
  .prd_act    (prd_act),
  .sector_sh  (sector_sh),
  .sector_act (sector_act),
  .inv_act    (inv_act),
  .up_hit     (up_hit),
  .dn_hit     (dn_hit),
  .pwm        (pwm)
);

// File: tb/azs_pwm_top_tb.sv
`timescale 1ns/1ps
module azs_pwm_top_tb;

  localparam int CNT_W = 16;
  localparam int NV    = 11;

  // period, sector, cmp a/b/c, expected high cycles per period a/b/c
  localparam int V_PRD [NV] = '{10, 10, 10, 10, 10, 10, 10, 10, 10, 10, 7};
  localparam int V_SEC [NV] = '{ 0,  1,  2,  3,  4,  5,  6,  7,  1,  2, 4};
  localparam int V_CA  [NV] = '{ 5,  4,  6,  3,  3,  3,  1,  2,  0,  9, 2};
  localparam int V_CB  [NV] = '{ 3,  6,  2,  5,  5,  5,  9,  2, 10,  1, 3};
  localparam int V_CC  [NV] = '{ 7,  2,  3,  7,  7,  7,  4,  2, 12,  0, 6};
  localparam int V_HA  [NV] = '{20,  8,  8,  6,  6, 14,  2, 20, 20,  2, 4};
  localparam int V_HB  [NV] = '{20,  8,  4, 10, 10, 10, 18, 20,  0,  2, 8};
  localparam int V_HC  [NV] = '{20,  4,  6,  6, 14, 14, 12, 20, 20, 20, 12};

  // Cycle-exact waveforms at P=4, bit k = level after the k-th edge
  localparam logic [15:0] WAVE_A = 16'b0001_1000_1000_0001;
  localparam logic [15:0] WAVE_B = 16'b1000_0001_0011_1100;
  localparam logic [15:0] WAVE_C = 16'b1100_0011_1110_0111;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] half_period_sh;
  logic [2:0]       sector_sh;
  logic [CNT_W-1:0] cmp_a_sh, cmp_b_sh, cmp_c_sh;
  logic             pwm_a, pwm_b, pwm_c;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  azs_pwm_top #(.CNT_W(CNT_W)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .half_period_sh (half_period_sh),
    .sector_sh      (sector_sh),
    .cmp_a_sh       (cmp_a_sh),
    .cmp_b_sh       (cmp_b_sh),
    .cmp_c_sh       (cmp_c_sh),
    .pwm_a          (pwm_a),
    .pwm_b          (pwm_b),
    .pwm_c          (pwm_c)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input int s, input int a, input int b, input int c);
    half_period_sh = CNT_W'(p);
    sector_sh      = 3'(s);
    cmp_a_sh       = CNT_W'(a);
    cmp_b_sh       = CNT_W'(b);
    cmp_c_sh       = CNT_W'(c);
  endtask

  initial begin
    drive(4, 1, 1, 2, 3);
    #35;
    // R8: reset state
    check("R8 reset pwm_a", int'(pwm_a), 0);
    check("R8 reset pwm_b", int'(pwm_b), 0);
    check("R8 reset pwm_c", int'(pwm_c), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R6: exact edges, shadows rewritten mid-period after edge 2
    for (int k = 0; k < 16; k++) begin
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R2/R3 wave a edge %0d", k), int'(pwm_a), int'(WAVE_A[k]));
      check($sformatf("R3/R4 wave b edge %0d", k), int'(pwm_b), int'(WAVE_B[k]));
      check($sformatf("R1/R2 wave c edge %0d", k), int'(pwm_c), int'(WAVE_C[k]));
      if (k == 2) drive(4, 2, 3, 1, 2); // R6: must not show before edge 8
    end

    // Table: high cycles over one full period in steady state (R1..R5, R7, R9)
    for (int v = 0; v < NV; v++) begin
      int ha, hb, hc;
      drive(V_PRD[v], V_SEC[v], V_CA[v], V_CB[v], V_CC[v]);
      repeat (48) @(negedge clk);
      ha = 0; hb = 0; hc = 0;
      for (int t = 0; t < 2 * V_PRD[v]; t++) begin
        @(negedge clk);
        ha += int'(pwm_a);
        hb += int'(pwm_b);
        hc += int'(pwm_c);
      end
      check($sformatf("R4/R5/R7/R9 vec %0d high a", v), ha, V_HA[v]);
      check($sformatf("R4/R5/R7/R9 vec %0d high b", v), hb, V_HB[v]);
      check($sformatf("R4/R5/R7/R9 vec %0d high c", v), hc, V_HC[v]);
    end

    // R8: reset asserted while running clears outputs at once
    drive(10, 5, 3, 5, 7);
    repeat (30) @(negedge clk);
    #3 rst_n = 1'b0;
    #2;
    check("R8 mid-run reset pwm_a", int'(pwm_a), 0);
    check("R8 mid-run reset pwm_b", int'(pwm_b), 0);
    check("R8 mid-run reset pwm_c", int'(pwm_c), 0);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule